// File: doc/BRIEF.md
# Reservation Monitor for Linked-Load / Conditional-Store

This block is a small shared data memory for several cores, with a monitor beside it that builds atomic read-modify-write sequences out of two separate accesses. A core issues a linked load. It gets the word back, and the monitor records a reservation for that core on that address. Later the same core issues a conditional store to the same address. The store writes memory only if the reservation has survived. It returns a status word: 1 when the store took effect and 0 when it did not. Software tests that status and repeats the whole load/store pair on zero.

A reservation is lost in three ways. Another core writes the reserved word. The owning core issues any conditional store. The owning core issues a linked load to another address. Each cycle a fixed-priority arbiter serves one requesting core, and the lowest index wins. A core that loses arbitration is not served, and it may present its request again. The two halves of a successful pair exchange a register value with the memory word. The old value comes from the linked load and the new value goes in with the conditional store.

Top module: `resv_mon_top`

## Requirements
- R1: After reset every word of memory reads 0, no reservation is held, no grant is given without a request, and no response is valid.
- R2: In each cycle at most one core is granted: the lowest-indexed core whose request is high. Request bits sit at position c of `req_i`. The op, address and data of core c sit at slice `[c*W +: W]` of the matching bus.
- R3: A granted core receives a response on `rsp_valid_o[c]` exactly one cycle later. Non-granted cores receive no response. A plain write (op 2'b01) responds with data 0.
- R4: A read (op 2'b00) or a linked load (op 2'b10) returns the memory word as it stood in the cycle of the grant.
- R5: A linked load records a reservation (valid, address) for the issuing core and replaces any reservation that core held before.
- R6: A conditional store (op 2'b11) whose core holds a valid reservation on the same address writes its data to memory and returns 1.
- R7: A conditional store with no valid reservation, or with a reservation on a different address, leaves memory unchanged and returns 0.
- R8: Every conditional store clears the issuing core's reservation, whether it succeeds or fails.
- R9: A committed write from another core (a plain write or a successful conditional store) to the reserved address clears the reservation. Writes to other addresses leave it intact.
- R10: A plain write by the reservation's own core does not clear that core's reservation.
- R11: When two cores present conditional stores to the same reserved word in the same cycle, the higher-priority core succeeds. The other core, served on a later cycle, fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCORE | Per-core request |
| op_i | input | 2*NCORE | Per-core op: 00 read, 01 write, 10 linked load, 11 conditional store |
| addr_i | input | AW*NCORE | Per-core word address |
| wdata_i | input | DW*NCORE | Per-core write data |
| gnt_o | output | NCORE | Same-cycle grant, one-hot or zero |
| rsp_valid_o | output | NCORE | Response valid, one cycle after grant |
| rdata_o | output | DW*NCORE | Per-core response data (read word or status) |

## Verification
The grant is combinational, so the bench samples `gnt_o` 1 ns after driving the requests in the low clock phase. It then compares the grant with the priority choice of its behavioural model. The response, the read word and the conditional-store status are all registered. They are due at the next falling edge after the grant edge, one cycle later, and the bench compares them there against the values its model captured in the grant cycle. Memory and reservation effects show up only through later reads and conditional stores. Each scenario therefore follows its stimulus with such an access on the following cycle.

// File: rtl/resv_mon_pkg.sv
package resv_mon_pkg;
   typedef enum logic [1:0] {
      OP_RD = 2'b00,
      OP_WR = 2'b01,
      OP_LL = 2'b10,
      OP_SC = 2'b11
   } mem_op_e;
endpackage

// File: rtl/resv_mon_arb.sv
module resv_mon_arb #(
   parameter int NCORE = 3,
   localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCORE-1:0] req_i,
   output logic [NCORE-1:0] gnt_o,
   output logic [IW-1:0]    idx_o,
   output logic             any_o
);
   always_comb begin
      gnt_o = '0;
      idx_o = '0;
      any_o = 1'b0;
      for (int i = 0; i < NCORE; i++) begin
         if (req_i[i] && !any_o) begin
            gnt_o[i] = 1'b1;
            idx_o    = IW'(i);
            any_o    = 1'b1;
         end
      end
   end

   // R2
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));
   // R2
   gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0);
   // R2
   no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i != '0) |-> $countones(gnt_o) == 1);
endmodule

// File: rtl/resv_mon_slot.sv
module resv_mon_slot #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic          clr_own_i,
   input  logic          wr_other_i,
   input  logic [AW-1:0] addr_i,
   output logic          valid_o,
   output logic [AW-1:0] addr_o
);
   logic hit;
   assign hit = valid_o && (addr_o == addr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
      end else if (set_i) begin
         valid_o <= 1'b1;
         addr_o  <= addr_i;
      end else if (clr_own_i) begin
         valid_o <= 1'b0;
      end else if (wr_other_i && hit) begin
         valid_o <= 1'b0;
      end
   end

   // R5
   ll_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> valid_o && addr_o == $past(addr_i));
   // R8
   sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_own_i |=> !valid_o);
   // R9
   snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_other_i && valid_o && addr_o == addr_i) |=> !valid_o);
   // R9
   snoop_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_other_i && valid_o && addr_o != addr_i && !set_i && !clr_own_i)
      |=> valid_o && $stable(addr_o));
endmodule

// File: rtl/resv_mon_top.sv
module resv_mon_top #(
   parameter int NCORE = 3,
   parameter int AW    = 4,
   parameter int DW    = 32,
   localparam int DEPTH = 1 << AW,
   localparam int IW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NCORE-1:0]    req_i,
   input  logic [2*NCORE-1:0]  op_i,
   input  logic [AW*NCORE-1:0] addr_i,
   input  logic [DW*NCORE-1:0] wdata_i,
   output logic [NCORE-1:0]    gnt_o,
   output logic [NCORE-1:0]    rsp_valid_o,
   output logic [DW*NCORE-1:0] rdata_o
);
   import resv_mon_pkg::*;

   if (NCORE < 2) begin : g_bad_ncore
      $error("resv_mon_top: NCORE must be at least 2");
   end
   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("resv_mon_top: AW must be within 1..10");
   end
   if (DW < 2) begin : g_bad_dw
      $error("resv_mon_top: DW must be at least 2");
   end

   logic [IW-1:0]    gidx;
   logic             any_gnt;
   mem_op_e          gop;
   logic [AW-1:0]    gaddr;
   logic [DW-1:0]    gwdata;
   logic [DW-1:0]    rd_word;
   logic             sc_ok;
   logic             commit_wr;
   logic [NCORE-1:0] res_valid;
   logic [AW-1:0]    res_addr [NCORE];
   logic [DW-1:0]    mem_q    [DEPTH];
   logic [DW-1:0]    rdata_q  [NCORE];

   resv_mon_arb #(.NCORE(NCORE)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_i),
      .gnt_o (gnt_o),
      .idx_o (gidx),
      .any_o (any_gnt)
   );

   always_comb begin
      gop    = OP_RD;
      gaddr  = '0;
      gwdata = '0;
      for (int c = 0; c < NCORE; c++) begin
         if (gnt_o[c]) begin
            gop    = mem_op_e'(op_i[2*c +: 2]);
            gaddr  = addr_i[AW*c +: AW];
            gwdata = wdata_i[DW*c +: DW];
         end
      end
   end

   assign rd_word   = mem_q[gaddr];
   assign sc_ok     = any_gnt && (gop == OP_SC) && res_valid[gidx]
                      && (res_addr[gidx] == gaddr);
   assign commit_wr = any_gnt && ((gop == OP_WR) || sc_ok);

   for (genvar c = 0; c < NCORE; c++) begin : g_slot
      resv_mon_slot #(.AW(AW)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_i      (gnt_o[c] && gop == OP_LL),
         .clr_own_i  (gnt_o[c] && gop == OP_SC),
         .wr_other_i (commit_wr && !gnt_o[c]),
         .addr_i     (gaddr),
         .valid_o    (res_valid[c]),
         .addr_o     (res_addr[c])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata_q[c] <= '0;
         end else if (gnt_o[c]) begin
            unique case (gop)
               OP_RD, OP_LL: rdata_q[c] <= rd_word;
               OP_SC:        rdata_q[c] <= DW'(sc_ok);
               default:      rdata_q[c] <= '0;
            endcase
         end
      end
      assign rdata_o[DW*c +: DW] = rdata_q[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= '0;
      end else begin
         rsp_valid_o <= gnt_o;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (commit_wr) begin
         mem_q[gaddr] <= gwdata;
      end
   end

   // R3
   rsp_follows_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_gnt |=> rsp_valid_o == $past(gnt_o));
   // R6
   sc_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_gnt && gop == OP_SC) |=> rdata_q[$past(gidx)] == DW'($past(sc_ok)));
   // R7
   sc_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_gnt && gop == OP_SC && !sc_ok) |=> mem_q[$past(gaddr)] == $past(rd_word));
   // R6
   sc_pass_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sc_ok |=> mem_q[$past(gaddr)] == $past(gwdata));
endmodule

// File: tb/resv_mon_top_bench.sv
`timescale 1ns/100ps
module resv_mon_top_bench;
   localparam int N  = 3;
   localparam int AW = 4;
   localparam int DW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_i = '0;
   logic [2*N-1:0]  op_i = '0;
   logic [AW*N-1:0] addr_i = '0;
   logic [DW*N-1:0] wdata_i = '0;
   logic [N-1:0]    gnt_o;
   logic [N-1:0]    rsp_valid_o;
   logic [DW*N-1:0] rdata_o;

   always #2.5 clk = ~clk;

   resv_mon_top #(.NCORE(N), .AW(AW), .DW(DW)) u_resv_mon_top (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .gnt_o(gnt_o),
      .rsp_valid_o(rsp_valid_o), .rdata_o(rdata_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural model
   logic [DW-1:0] m_mem [16];
   bit            m_rv  [N];
   int            m_ra  [N];
   bit            e_v   [N];
   logic [DW-1:0] e_d   [N];
   // stimulus staging
   bit            s_rq  [N];
   int            s_op  [N];
   int            s_ad  [N];
   logic [DW-1:0] s_wd  [N];

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic put(input int c, input int op, input int ad, input logic [DW-1:0] wd);
      s_rq[c] = 1; s_op[c] = op; s_ad[c] = ad; s_wd[c] = wd;
   endtask

   // one clock: drive in low phase, check grant, then check responses next low phase
   task automatic tick(input string tag);
      int g;
      logic [N-1:0] eg;
      for (int c = 0; c < N; c++) begin
         req_i[c]            = s_rq[c];
         op_i[2*c +: 2]      = 2'(s_op[c]);
         addr_i[AW*c +: AW]  = AW'(s_ad[c]);
         wdata_i[DW*c +: DW] = s_wd[c];
      end
      #1;
      g = -1;
      for (int c = 0; c < N; c++) if (s_rq[c] && g < 0) g = c;
      eg = (g >= 0) ? N'(1 << g) : '0;
      check(gnt_o === eg, {tag, " grant R2"}, DW'(gnt_o), DW'(eg));
      for (int c = 0; c < N; c++) e_v[c] = 0;
      if (g >= 0) begin
         int a;
         bit ok;
         a = s_ad[g];
         e_v[g] = 1;
         case (s_op[g])
            0: e_d[g] = m_mem[a];
            2: begin e_d[g] = m_mem[a]; m_rv[g] = 1; m_ra[g] = a; end
            1: begin
               e_d[g] = 0; m_mem[a] = s_wd[g];
               for (int k = 0; k < N; k++) if (k != g && m_ra[k] == a) m_rv[k] = 0;
            end
            default: begin
               ok = m_rv[g] && m_ra[g] == a;
               e_d[g] = DW'(ok);
               m_rv[g] = 0;
               if (ok) begin
                  m_mem[a] = s_wd[g];
                  for (int k = 0; k < N; k++) if (k != g && m_ra[k] == a) m_rv[k] = 0;
               end
            end
         endcase
      end
      for (int c = 0; c < N; c++) s_rq[c] = 0;
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
         check(rsp_valid_o[c] === e_v[c], {tag, " response R3"},
               DW'(rsp_valid_o[c]), DW'(e_v[c]));
         if (e_v[c])
            check(rdata_o[DW*c +: DW] === e_d[c], {tag, " data"},
                  rdata_o[DW*c +: DW], e_d[c]);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      for (int c = 0; c < N; c++) begin
         m_rv[c] = 0; m_ra[c] = -1; s_rq[c] = 0; s_op[c] = 0; s_ad[c] = 0; s_wd[c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle state after reset
      check(rsp_valid_o === '0, "R1 reset rsp", DW'(rsp_valid_o), 0);
      tick("R1 idle");
      put(0, 3, 3, 32'h55); tick("R1 sc without reservation");
      put(1, 0, 3, 0);      tick("R1 read zero");
      // R4 plain write then read; R2 priority between read and write
      put(1, 1, 2, 32'hA1A1); tick("R3 write");
      put(2, 1, 2, 32'hB2B2); put(0, 0, 2, 0); tick("R2 read beats write");
      put(2, 1, 2, 32'hB2B2); tick("R4 write held");
      put(1, 0, 2, 0); tick("R4 read back");
      // R6 exchange; R8 second SC fails
      put(0, 2, 2, 0); tick("R6 ll");
      put(0, 3, 2, 32'hC0DE); tick("R6 sc pass");
      put(0, 3, 2, 32'hDEAD); tick("R8 sc again");
      put(2, 0, 2, 0); tick("R8 memory kept");
      // R7 address mismatch
      put(1, 2, 4, 0); tick("R7 ll");
      put(1, 3, 5, 32'h77); tick("R7 sc other addr");
      put(1, 0, 5, 0); tick("R7 memory kept");
      // R9 unrelated write keeps, matching write kills
      put(2, 2, 6, 0); tick("R9 ll");
      put(0, 1, 7, 32'h7); tick("R9 other addr write");
      put(2, 3, 6, 32'h66); tick("R9 sc survives");
      put(2, 2, 6, 0); tick("R9 ll again");
      put(1, 1, 6, 32'h16); tick("R9 snoop write");
      put(2, 3, 6, 32'h99); tick("R9 sc broken");
      put(0, 0, 6, 0); tick("R9 memory kept");
      // R10 own write keeps reservation
      put(0, 2, 8, 0); tick("R10 ll");
      put(0, 1, 8, 32'h88); tick("R10 own write");
      put(0, 3, 8, 32'h89); tick("R10 sc pass");
      // R5 reservation replaced by newer LL
      put(2, 2, 10, 0); tick("R5 ll first");
      put(2, 2, 11, 0); tick("R5 ll second");
      put(2, 3, 10, 32'hAA); tick("R5 sc old addr");
      put(2, 2, 11, 0); tick("R5 ll third");
      put(2, 3, 11, 32'hBB); tick("R5 sc new addr");
      // R11 simultaneous SCs
      put(0, 2, 9, 0); put(1, 2, 9, 0); tick("R11 ll both a");
      put(1, 2, 9, 0); tick("R11 ll both b");
      put(0, 3, 9, 32'h900); put(1, 3, 9, 32'h901); tick("R11 race");
      put(1, 3, 9, 32'h901); tick("R11 loser");
      put(2, 0, 9, 0); tick("R11 result");
      put(0, 0, 2, 0); put(1, 0, 4, 0); put(2, 0, 8, 0); tick("R2 three way");
      put(1, 0, 4, 0); put(2, 0, 8, 0); tick("R2 two way");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule